// File: doc/BRIEF.md
# Six-state self-correcting JK counter

This block is a 3-bit synchronous counter. It is built from three JK-style storage elements. Each element's J and K inputs come from a fixed set of excitation equations, and the state does not advance by binary increment. The equations walk the state through a six-code cycle: 000, 001, 010, 100, 101, 110, then back to 000. The counter can be used as a divide-by-six sequencer, and its codes can be decoded into timing phases.

Two of the eight 3-bit codes, 011 and 111, are outside the cycle. A supply glitch, an upset or a forced value can leave the register holding one of them. The same equations take 011 to 100 and 111 to 000 in a single enabled clock, so the counter never stays outside the cycle. A flag output goes high while the register holds an unused code, which lets the surrounding logic discard that phase.

Top module: `hexa_cycle_ctr`

## Requirements
- R1: When `rst` is high at a rising clock edge, `state_o` becomes 000 and `illegal_o` is low, whatever the level of `en`.
- R2: When `rst` is low and `en` is low at a rising edge, `state_o` keeps its value.
- R3: With `en` high and `rst` low, valid codes advance one step per clock in the order 000, 001, 010, 100, 101, 110, and 110 returns to 000. Bit 2 is element A (most significant), bit 1 is element B and bit 0 is element C.
- R4: From the unused code 011, one enabled clock moves `state_o` to 100.
- R5: From the unused code 111, one enabled clock moves `state_o` to 000.
- R6: `illegal_o` is high exactly when `state_o` is 011 or 111, that is, when bits 1 and 0 are both 1. It is low for every code in the six-state cycle.
- R7: After recovering from an unused code, the counter follows the R3 cycle on every later enabled clock and never returns to an unused code.
- R8: Both outputs come only from the storage elements, so they change only at rising clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes happen on its rising edge |
| rst | input | 1 | Synchronous active-high reset to code 000 |
| en | input | 1 | Count enable; when low the state holds |
| state_o | output | 3 | Current counter code, bit 2 = A, bit 1 = B, bit 0 = C |
| illegal_o | output | 1 | High while the current code is one of the unused codes |

## Verification
The bench builds the block with its only configuration, the 3-bit width fixed in the package. At that width all eight codes can be reached, both the six in the cycle and the two unused ones. The two unused codes cannot be reached through the ports, so the bench writes them into the storage elements right after a reset. It then follows each recovery and the complete cycle that comes after it. Enable-low holds and resets taken with enable low are placed at several points in the cycle. A behavioural model built from an ordered list of codes is compared with both outputs on every clock.

// File: rtl/hexa_pkg.sv
package hexa_pkg;
  localparam int CTR_BITS = 3;
  localparam int BIT_A    = 2;
  localparam int BIT_B    = 1;
  localparam int BIT_C    = 0;

  typedef logic [CTR_BITS-1:0] code_t;

  localparam code_t CODE_ZERO = 3'b000;
  localparam code_t CODE_LAST = 3'b110;
  localparam code_t CODE_U3   = 3'b011;
  localparam code_t CODE_U7   = 3'b111;
  localparam code_t CODE_FOUR = 3'b100;
endpackage

// File: rtl/hexa_jk_cell.sv
module hexa_jk_cell (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic j,
  input  logic k,
  output logic q
);
  logic q_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_r <= 1'b0;
    end else if (en) begin
      case ({j, k})
        2'b00:   q_r <= q_r;
        2'b01:   q_r <= 1'b0;
        2'b10:   q_r <= 1'b1;
        default: q_r <= ~q_r;
      endcase
    end
  end

  assign q = q_r;
endmodule

// File: rtl/hexa_excite.sv
module hexa_excite
  import hexa_pkg::*;
(
  input  code_t cur,
  output code_t j_vec,
  output code_t k_vec
);
  always_comb begin
    j_vec        = '0;
    k_vec        = '0;
    // element A toggles whenever B is set
    j_vec[BIT_A] = cur[BIT_B];
    k_vec[BIT_A] = cur[BIT_B];
    // element B sets from C and always clears otherwise
    j_vec[BIT_B] = cur[BIT_C];
    k_vec[BIT_B] = 1'b1;
    // element C sets only while B is clear
    j_vec[BIT_C] = ~cur[BIT_B];
    k_vec[BIT_C] = 1'b1;
  end
endmodule

// File: rtl/hexa_cycle_ctr.sv
module hexa_cycle_ctr
  import hexa_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  output logic [CTR_BITS-1:0] state_o,
  output logic                illegal_o
);
  code_t cur;
  code_t j_vec;
  code_t k_vec;

  hexa_excite u_excite (
    .cur   (cur),
    .j_vec (j_vec),
    .k_vec (k_vec)
  );

  for (genvar gi = 0; gi < CTR_BITS; gi++) begin : g_bit
    hexa_jk_cell u_cell (
      .clk (clk),
      .rst (rst),
      .en  (en),
      .j   (j_vec[gi]),
      .k   (k_vec[gi]),
      .q   (cur[gi])
    );
  end

  // unused codes are exactly those with B and C both set
  assign illegal_o = cur[BIT_B] & cur[BIT_C];
  assign state_o   = cur;

  // R3: the cycle wraps from its last code to zero
  a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
    (en && cur == CODE_LAST) |=> (cur == CODE_ZERO));

  // R4: recovery from 011
  a_r4_from_three: assert property (@(posedge clk) disable iff (rst)
    (en && cur == CODE_U3) |=> (cur == CODE_FOUR));

  // R5: recovery from 111
  a_r5_from_seven: assert property (@(posedge clk) disable iff (rst)
    (en && cur == CODE_U7) |=> (cur == CODE_ZERO));

  // R2: hold while disabled
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (!en) |=> $stable(state_o));

  // R6: the flag never stays high across an enabled clock
  a_r6_flag_clears: assert property (@(posedge clk) disable iff (rst)
    (en && illegal_o) |=> !illegal_o);

  // R7: a valid code never leads into an unused one
  a_r7_stays_valid: assert property (@(posedge clk) disable iff (rst)
    (en && !illegal_o) |=> !illegal_o);
endmodule

// File: tb/hexa_cycle_ctr_tb_top.sv
module hexa_cycle_ctr_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic [2:0] state_o;
  logic       illegal_o;

  int checks = 0;
  int fails  = 0;
  logic [2:0] model = 3'b000;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  hexa_cycle_ctr dut_i (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .state_o   (state_o),
    .illegal_o (illegal_o)
  );

  function automatic logic [2:0] ref_next(input logic [2:0] s);
    logic [2:0] order [6];
    order = '{3'd0, 3'd1, 3'd2, 3'd4, 3'd5, 3'd6};
    if (s == 3'd3) return 3'd4;
    if (s == 3'd7) return 3'd0;
    for (int i = 0; i < 6; i++)
      if (order[i] == s) return order[(i + 1) % 6];
    return 3'd0;
  endfunction

  task automatic check(input string req);
    logic exp_flag;
    exp_flag = (model == 3'd3) || (model == 3'd7);
    checks++;
    if (state_o !== model || illegal_o !== exp_flag) begin
      fails++;
      $display("FAIL %s: state=%b flag=%b expected state=%b flag=%b",
               req, state_o, illegal_o, model, exp_flag);
    end
  endtask

  // one clock: model follows the sampled inputs, outputs checked at the falling edge
  task automatic tick(input string req);
    @(posedge clk);
    if (rst) model = 3'd0;
    else if (en) model = ref_next(model);
    @(negedge clk);
    check(req);
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick("R1");
    tick("R1");
    rst = 1'b0;
    en  = 1'b1;
    for (int i = 0; i < 13; i++) tick("R3");
    en = 1'b0;
    for (int i = 0; i < 3; i++) tick("R2");
    en = 1'b1;
    for (int i = 0; i < 2; i++) tick("R8");
    en = 1'b0;
    rst = 1'b1;
    tick("R1");
    rst = 1'b0;
    tick("R2");

    // place 011 in the storage elements right after a reset
    en = 1'b1;
    rst = 1'b1;
    tick("R1");
    force dut_i.g_bit[2].u_cell.q_r = 1'b0;
    force dut_i.g_bit[1].u_cell.q_r = 1'b1;
    force dut_i.g_bit[0].u_cell.q_r = 1'b1;
    rst = 1'b0;
    #1;
    release dut_i.g_bit[2].u_cell.q_r;
    release dut_i.g_bit[1].u_cell.q_r;
    release dut_i.g_bit[0].u_cell.q_r;
    model = 3'd3;
    #1 check("R6");
    tick("R4");
    for (int i = 0; i < 7; i++) tick("R7");

    // place 111 in the storage elements
    rst = 1'b1;
    tick("R1");
    force dut_i.g_bit[2].u_cell.q_r = 1'b1;
    force dut_i.g_bit[1].u_cell.q_r = 1'b1;
    force dut_i.g_bit[0].u_cell.q_r = 1'b1;
    rst = 1'b0;
    #1;
    release dut_i.g_bit[2].u_cell.q_r;
    release dut_i.g_bit[1].u_cell.q_r;
    release dut_i.g_bit[0].u_cell.q_r;
    model = 3'd7;
    #1 check("R6");
    tick("R5");
    for (int i = 0; i < 7; i++) tick("R7");

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule